// File: doc/BRIEF.md
# Two-Channel Prescaled Down-Counting Timer

This block is a small memory-mapped timer with two independent channels, reached through a flat register bus. The bus has an address, write data, a write strobe and a combinational read port. Each channel has a control register, a start-count (compare) register and a read-only live count. An 8-bit prescaler divides the clock by prescale+1 before it reaches a 24-bit down-counter. When a channel expires it sets its flag in a shared status register. Software clears those flags by writing ones to them.

A channel runs either once or periodically. In one-shot mode it stops itself and holds at zero when it expires. In periodic mode it reloads from its compare register and keeps counting, which gives a regular tick. A periodic channel with a full-scale compare value and its interrupt masked serves as a free-running time base whose value software reads back. Each channel drives its own interrupt line.

Each channel is a two-state machine with states CH_IDLE and CH_RUN. The transitions are:
- START (CH_IDLE to CH_RUN): a control write with the enable bit set.
- STOP (CH_RUN to CH_IDLE): a control write with the enable bit clear.
- EXPIRE_ONCE (CH_RUN to CH_IDLE): expiry in one-shot mode with no control write in the same cycle.
- STAY (CH_RUN to CH_RUN): any other cycle in CH_RUN, including a periodic reload.

Top module: `ptimer_top`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: Control layout: bit 30 enable (reads 1 in CH_RUN), bit 29 interrupt enable, bits 28:27 mode, bits 7:0 prescale. All other bits read zero. Control 0 is at 0x00 and control 1 is at 0x04.
- R3: The count loads from the compare register when the enable bit goes 0 to 1. Writing the compare register (0x08 for channel 0, 0x0C for channel 1) loads the count directly. Both events restart the prescaler.
- R4: While the channel is running, the count steps down by one every prescale+1 clocks. A step occurs in every cycle in which the prescaler phase has reached the prescale value.
- R5: Mode bit 27 = 0 selects one-shot. On a step from a count of 1 or 0, the channel sets its flag, clears its enable and holds the count at 0.
- R6: Mode bit 27 = 1 selects periodic. On a step from a count of 1 or 0, the channel sets its flag and reloads the compare value, so the period is compare×(prescale+1) clocks.
- R7: The status register is at 0x18, with bit 0 for channel 0 and bit 1 for channel 1. Writing a 1 clears a flag and writing a 0 leaves it unchanged, so 0x1F clears every flag.
- R8: When a flag is set and cleared in the same cycle, the set wins.
- R9: Each interrupt line is high exactly while its channel's flag is set and its interrupt-enable bit is 1.
- R10: Writing zero to a control register stops the channel. The count then holds its value.
- R11: The data registers at 0x10 and 0x14 show the live count in bits 23:0. The compare register holds 24 bits. Upper bits read zero.
- R12: The two channels count, expire and flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Interrupt line for each channel |

## Verification
Register writes take effect at the clock edge that samples them. Read data is a combinational function of the address and the state after that edge. A step, an expiry flag and the matching interrupt all appear at the same edge, namely edge k+N×(prescale+1) after a start at edge k for a count of N. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. One nanosecond after each falling edge it compares read data and both interrupt lines against the model, so every result is checked in the exact cycle it is due.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int unsigned EN_BIT   = 30;
    localparam int unsigned IE_BIT   = 29;
    localparam int unsigned MODE_HI  = 28;
    localparam int unsigned MODE_LO  = 27;
    localparam int unsigned PERIODIC_BIT = 0; // within the mode field
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    // A phase beyond the limit (after the limit was lowered) also steps.
    assign tick = run && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
    import ptimer_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             w_en,
    input  logic             w_ie,
    input  logic [1:0]       w_mode,
    input  logic [PRE_W-1:0] w_pre,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] w_cmp,
    output logic             en_o,
    output logic             ie_o,
    output logic [1:0]       mode_o,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    ch_state_e        state_q, state_d;
    logic             ie_q;
    logic [1:0]       mode_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cmp_q, cnt_q, cnt_d;
    logic             running, start, step, expire, periodic;

    assign running  = (state_q == CH_RUN);
    assign start    = (state_q == CH_IDLE) && ctrl_we && w_en;
    assign periodic = mode_q[PERIODIC_BIT];
    assign expire   = step && (cnt_q <= CNT_W'(1));

    ptimer_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .restart(start || cmp_we),
        .limit  (pre_q),
        .tick   (step)
    );

    // Next-state logic: START, STOP, EXPIRE_ONCE, STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctrl_we && w_en) state_d = CH_RUN;          // START
            end
            CH_RUN: begin
                if (ctrl_we && !w_en) state_d = CH_IDLE;        // STOP
                else if (!ctrl_we && expire && !periodic)
                    state_d = CH_IDLE;                          // EXPIRE_ONCE
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Count next value
    always_comb begin
        cnt_d = cnt_q;
        if (cmp_we)      cnt_d = w_cmp;
        else if (start)  cnt_d = cmp_q;
        else if (step)   cnt_d = expire ? (periodic ? cmp_q : '0) : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mode_q <= '0;
            pre_q  <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (ctrl_we) begin
                ie_q   <= w_ie;
                mode_q <= w_mode;
                pre_q  <= w_pre;
            end
            if (cmp_we) cmp_q <= w_cmp;
        end
    end

    // Output process
    always_comb begin
        en_o     = running;
        ie_o     = ie_q;
        mode_o   = mode_q;
        pre_o    = pre_q;
        cmp_o    = cmp_q;
        cnt_o    = cnt_q;
        expire_o = expire;
    end

    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cmp_we) |=> (cnt_q == $past(cmp_q)));
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic && !ctrl_we && !cmp_we) |=> (!en_o && cnt_q == '0));
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic && !cmp_we) |=> (cnt_q == $past(cmp_q)));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_we && !cmp_we) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer_status.sv
module ptimer_status #(
    parameter int unsigned N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic            clr_we,
    input  logic [N_CH-1:0] clr_mask,
    output logic [N_CH-1:0] flags_o
);
    logic [N_CH-1:0] flags_q;
    logic [N_CH-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_eff) | set_i;
    end

    assign flags_o = flags_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[i] && !set_i[i]) |=> !flags_o[i]);
    end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int unsigned N_CH   = 2,
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   irq
);
    localparam int unsigned CTRL_BASE = 0;
    localparam int unsigned CMP_BASE  = 4 * N_CH;
    localparam int unsigned DATA_BASE = 8 * N_CH;
    localparam int unsigned STAT_ADDR = 12 * N_CH;

    logic [N_CH-1:0]  en, ie, expire;
    logic [1:0]       mode [N_CH];
    logic [PRE_W-1:0] pre  [N_CH];
    logic [CNT_W-1:0] cmp  [N_CH];
    logic [CNT_W-1:0] cnt  [N_CH];
    logic [N_CH-1:0]  flags;
    logic             stat_we;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[DATA_W-1], bus_wdata[MODE_LO-1:CNT_W]};

    assign stat_we = bus_we && (bus_addr == ADDR_W'(STAT_ADDR));

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic ctrl_we_c, cmp_we_c;
        assign ctrl_we_c = bus_we && (bus_addr == ADDR_W'(CTRL_BASE + 4 * c));
        assign cmp_we_c  = bus_we && (bus_addr == ADDR_W'(CMP_BASE + 4 * c));

        ptimer_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we_c),
            .w_en    (bus_wdata[EN_BIT]),
            .w_ie    (bus_wdata[IE_BIT]),
            .w_mode  (bus_wdata[MODE_HI:MODE_LO]),
            .w_pre   (bus_wdata[PRE_W-1:0]),
            .cmp_we  (cmp_we_c),
            .w_cmp   (bus_wdata[CNT_W-1:0]),
            .en_o    (en[c]),
            .ie_o    (ie[c]),
            .mode_o  (mode[c]),
            .pre_o   (pre[c]),
            .cmp_o   (cmp[c]),
            .cnt_o   (cnt[c]),
            .expire_o(expire[c])
        );

        assign irq[c] = flags[c] & ie[c];
    end

    ptimer_status #(.N_CH(N_CH)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (expire),
        .clr_we  (stat_we),
        .clr_mask(bus_wdata[N_CH-1:0]),
        .flags_o (flags)
    );

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (bus_addr == ADDR_W'(CTRL_BASE + 4 * c)) begin
                bus_rdata[EN_BIT]          = en[c];
                bus_rdata[IE_BIT]          = ie[c];
                bus_rdata[MODE_HI:MODE_LO] = mode[c];
                bus_rdata[PRE_W-1:0]       = pre[c];
            end
            if (bus_addr == ADDR_W'(CMP_BASE + 4 * c))  bus_rdata[CNT_W-1:0] = cmp[c];
            if (bus_addr == ADDR_W'(DATA_BASE + 4 * c)) bus_rdata[CNT_W-1:0] = cnt[c];
        end
        if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata[N_CH-1:0] = flags;
    end
endmodule

// File: tb/tb_ptimer_top.sv
`timescale 1ns/1ps
module tb_ptimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    ptimer_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // Behavioural reference model
    logic        m_en [2];
    logic        m_ie [2];
    logic [1:0]  m_mode [2];
    logic [7:0]  m_pre [2];
    logic [7:0]  m_psc [2];
    logic [23:0] m_cmp [2];
    logic [23:0] m_cnt [2];
    logic [1:0]  m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_en[c] = 0; m_ie[c] = 0; m_mode[c] = 0; m_pre[c] = 0;
                m_psc[c] = 0; m_cmp[c] = 0; m_cnt[c] = 0;
            end
            m_flag = 0;
        end else begin
            logic [1:0] setv;
            setv = 0;
            for (int c = 0; c < 2; c++) begin
                logic tk, ex, cw, kw, st;
                tk = m_en[c] && (m_psc[c] >= m_pre[c]);
                ex = tk && (m_cnt[c] <= 1);
                cw = we && (addr == 5'(4 * c));
                kw = we && (addr == 5'(8 + 4 * c));
                st = cw && wdata[30] && !m_en[c];
                setv[c] = ex;
                if (kw || st) m_psc[c] = 0;
                else if (m_en[c]) m_psc[c] = tk ? 8'd0 : m_psc[c] + 8'd1;
                if (kw) m_cnt[c] = wdata[23:0];
                else if (st) m_cnt[c] = m_cmp[c];
                else if (tk) m_cnt[c] = ex ? (m_mode[c][0] ? m_cmp[c] : 24'd0) : m_cnt[c] - 24'd1;
                if (cw) m_en[c] = wdata[30];
                else if (ex && !m_mode[c][0]) m_en[c] = 0;
                if (cw) begin
                    m_ie[c] = wdata[29]; m_mode[c] = wdata[28:27]; m_pre[c] = wdata[7:0];
                end
                if (kw) m_cmp[c] = wdata[23:0];
            end
            m_flag = (m_flag & ~((we && addr == 5'h18) ? wdata[1:0] : 2'b00)) | setv;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            5'h00, 5'h04: begin
                r[30] = m_en[a[2]]; r[29] = m_ie[a[2]];
                r[28:27] = m_mode[a[2]]; r[7:0] = m_pre[a[2]];
            end
            5'h08, 5'h0C: r[23:0] = m_cmp[a[2]];
            5'h10, 5'h14: r[23:0] = m_cnt[a[2]];
            5'h18: r[1:0] = m_flag;
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check({cur_req, " rdata"}, rdata, exp_rd(addr));
            check({cur_req, " R9 irq"}, {30'd0, irq},
                  {30'd0, m_flag & {m_ie[1], m_ie[0]}});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic watch(input logic [4:0] a, input int n);
        @(negedge clk);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: directed reset values
        for (int a = 0; a < 7; a++) begin
            addr = 5'(4 * a);
            #1;
            check("R1 reset read", rdata, 32'd0);
            @(negedge clk);
        end
        check("R1 reset irq", {30'd0, irq}, 32'd0);

        // R5/R4: one-shot ch0, cmp 5, prescale 2, irq enabled
        cur_req = "R5";
        wr(5'h08, 32'd5);
        wr(5'h00, (32'd1 << 30) | (32'd1 << 29) | 32'd2);
        cur_req = "R4";
        watch(5'h10, 20);
        cur_req = "R5";
        watch(5'h00, 2);
        watch(5'h18, 2);
        cur_req = "R7";
        wr(5'h18, 32'd1);
        watch(5'h18, 2);

        // R6/R12: ch1 periodic cmp 3 pre 0, ch0 periodic cmp 4 pre 1 masked
        cur_req = "R12";
        wr(5'h0C, 32'd3);
        wr(5'h08, 32'd4);
        wr(5'h04, (32'd1 << 30) | (32'd1 << 29) | (32'd1 << 27));
        wr(5'h00, (32'd1 << 30) | (32'd1 << 27) | 32'd1);
        cur_req = "R6";
        watch(5'h14, 14);
        watch(5'h10, 10);
        cur_req = "R7";
        wr(5'h18, 32'd0);
        watch(5'h18, 1);
        wr(5'h18, 32'h1F);
        watch(5'h18, 1);

        // R8: clear every cycle while ch1 keeps expiring
        cur_req = "R8";
        @(negedge clk);
        addr = 5'h18; wdata = 32'd2; we = 1'b1;
        repeat (10) @(negedge clk);
        we = 1'b0;
        watch(5'h18, 2);

        // R10: stop ch1, count holds
        cur_req = "R10";
        wr(5'h04, 32'd0);
        watch(5'h14, 8);
        watch(5'h04, 1);

        // R3: compare write while ch0 runs reloads the count
        cur_req = "R3";
        wr(5'h08, 32'd9);
        watch(5'h10, 6);

        // R11: full-scale free-running time base
        cur_req = "R11";
        wr(5'h0C, 32'hFFFF_FFFF);
        watch(5'h0C, 1);
        wr(5'h04, (32'd1 << 30) | (32'd1 << 27));
        watch(5'h14, 10);

        // R2: control field layout with all bits written
        cur_req = "R2";
        wr(5'h00, 32'hFFFF_FFFF);
        watch(5'h00, 2);
        check("R2 ctrl readback", rdata, 32'h7800_00FF);
        wr(5'h00, 32'd0);
        wr(5'h04, 32'd0);
        watch(5'h00, 2);

        finish_run();
    end
endmodule